// File: doc/BRIEF.md
# Reversible Gate Cascade Evaluator

The block holds a programmable chain of reversible gates and runs vectors of `NW` wires through it. Each of the `NS` cascade slots carries one gate descriptor. A descriptor is one of three things: an empty slot, a multi-controlled inverter or a wire exchange. The multi-controlled inverter covers the plain inverter with no controls, the single-control inverter, the two-control inverter and any larger control set. Vectors pass through the slots in ascending slot order, one slot per pipeline stage. The output is therefore the composition of the gates: slot 0 first, then slot 1 applied to its result, and so on.

Software loads the slots through a write port. Every descriptor is checked when it is written. A descriptor that would not be a reversible gate on distinct wires is refused, reported on `cfg_reject`, and stored as an empty slot, so the cascade always remains a bijection on the 2^NW input values.

Vectors enter through a valid/ready input. A sweep request makes the block inject every value from 0 to 2^NW-1 on its own, which emits the whole permutation table of the programmed cascade. Each result comes out with the vector that produced it.

Top module: `rev_cascade`

## Requirements
- R1: After reset `out_valid`, `sweep_busy` and `cfg_reject` are 0, `in_ready` is 1, and every slot is empty.
- R2: A vector accepted in cycle c (`in_valid` and `in_ready` both 1) appears with `out_valid`=1 in cycle c+NS, and in no other cycle. `out_src` carries the accepted vector.
- R3: A slot of kind 2'b01 with control mask `m` and target `t` inverts bit `t` exactly when every bit set in `m` is 1 in its input, and leaves all other bits unchanged. A zero mask always inverts the target.
- R4: A slot of kind 2'b10 with wires `t` and `a` exchanges bits `t` and `a` and leaves the other bits unchanged.
- R5: The slots are applied in ascending slot order, each one to the result of the previous one.
- R6: A slot of kind 2'b00 passes its vector through unchanged, so empty slots may sit anywhere in the chain.
- R7: A write is illegal if it has kind 2'b11, an index of NW or more, a kind 2'b01 mask with bit `t` set, or a kind 2'b10 with `t`=`a`. For an illegal write, `cfg_reject` is 1 in the cycle after the write and the slot becomes empty, replacing its previous content. A legal write leaves `cfg_reject` at 0.
- R8: A `sweep_start` pulse while idle makes the block emit 2^NW results on consecutive cycles, with `out_src` running from 0 to 2^NW-1.
- R9: The `out_data` values of one sweep are pairwise distinct.
- R10: While `sweep_busy` is 1, `in_ready` is 0 and `in_valid` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_slot | input | SW | Slot index being written |
| cfg_kind | input | 2 | 00 empty, 01 controlled inverter, 10 exchange, 11 illegal |
| cfg_tgt | input | IW | Target wire, or first exchanged wire |
| cfg_aux | input | IW | Second exchanged wire |
| cfg_mask | input | NW | Control wire mask |
| cfg_reject | output | 1 | Previous-cycle write was refused |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Block accepts an input vector |
| in_data | input | NW | Input vector |
| sweep_start | input | 1 | Request a full-table sweep |
| sweep_busy | output | 1 | Sweep injection in progress |
| out_valid | output | 1 | Result valid |
| out_data | output | NW | Cascade result |
| out_src | output | NW | Vector that produced the result |

## Verification
Several properties are checked on every cycle by assertions:
- no result appears without an earlier accepted vector;
- no result appears in the first NS cycles after reset;
- a refusal always follows a write;
- `in_ready` is held low during a sweep;
- a sweep lasts exactly 2^NW cycles;
- any two consecutive results from distinct sources differ once the configuration has been quiet long enough.

The bench scenarios are the only source of evidence for the gate semantics: the control masks, the exchanges, slot ordering, identity for empty and refused slots, and the exact output cycle. They also show the sweep table in full against a model built from the requirements.

// File: rtl/rev_cascade.sv
module rev_cascade #(
  parameter int NW = 4,
  parameter int NS = 8,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_slot,
  input  logic [1:0]    cfg_kind,
  input  logic [IW-1:0] cfg_tgt,
  input  logic [IW-1:0] cfg_aux,
  input  logic [NW-1:0] cfg_mask,
  output logic          cfg_reject,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [NW-1:0] in_data,
  input  logic          sweep_start,
  output logic          sweep_busy,
  output logic          out_valid,
  output logic [NW-1:0] out_data,
  output logic [NW-1:0] out_src
);
  localparam logic [1:0] K_NONE = 2'b00, K_CX = 2'b01, K_SWAP = 2'b10;

  logic [1:0]    s_kind [NS];
  logic [IW-1:0] s_tgt  [NS];
  logic [IW-1:0] s_aux  [NS];
  logic [NW-1:0] s_mask [NS];

  logic          p_v [NS];
  logic [NW-1:0] p_d [NS];
  logic [NW-1:0] p_s [NS];

  logic [NW-1:0] cnt;
  logic          illegal;

  function automatic logic [NW-1:0] gate_apply(input logic [1:0] k, input logic [IW-1:0] t,
      input logic [IW-1:0] a, input logic [NW-1:0] m, input logic [NW-1:0] v);
    logic [NW-1:0] r;
    r = v;
    if (k == K_CX && (v & m) == m) r[t] = ~v[t];
    else if (k == K_SWAP) begin
      r[t] = v[a];
      r[a] = v[t];
    end
    return r;
  endfunction

  assign illegal = (cfg_kind == 2'b11)
                || (32'(cfg_tgt) >= NW)
                || (cfg_kind == K_CX && cfg_mask[cfg_tgt])
                || (cfg_kind == K_SWAP && (32'(cfg_aux) >= NW || cfg_aux == cfg_tgt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_reject <= 1'b0;
      for (int i = 0; i < NS; i++) begin
        s_kind[i] <= K_NONE;
        s_tgt[i]  <= '0;
        s_aux[i]  <= '0;
        s_mask[i] <= '0;
      end
    end else begin
      cfg_reject <= cfg_we && illegal;
      if (cfg_we && 32'(cfg_slot) < NS) begin
        s_kind[cfg_slot] <= illegal ? K_NONE : cfg_kind;
        s_tgt[cfg_slot]  <= cfg_tgt;
        s_aux[cfg_slot]  <= cfg_aux;
        s_mask[cfg_slot] <= cfg_mask;
      end
    end
  end

  assign in_ready = !sweep_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweep_busy <= 1'b0;
      cnt        <= '0;
    end else if (sweep_busy) begin
      cnt <= cnt + 1'b1;
      if (&cnt) sweep_busy <= 1'b0;
    end else if (sweep_start) begin
      sweep_busy <= 1'b1;
      cnt        <= '0;
    end
  end

  logic          inj_v;
  logic [NW-1:0] inj_d;
  assign inj_v = sweep_busy || in_valid;
  assign inj_d = sweep_busy ? cnt : in_data;

  for (genvar g = 0; g < NS; g++) begin : g_stage
    logic          prev_v;
    logic [NW-1:0] prev_d, prev_s;
    if (g == 0) begin : g_first
      assign prev_v = inj_v;
      assign prev_d = inj_d;
      assign prev_s = inj_d;
    end else begin : g_next
      assign prev_v = p_v[g-1];
      assign prev_d = p_d[g-1];
      assign prev_s = p_s[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_v[g] <= 1'b0;
        p_d[g] <= '0;
        p_s[g] <= '0;
      end else begin
        p_v[g] <= prev_v;
        p_d[g] <= gate_apply(s_kind[g], s_tgt[g], s_aux[g], s_mask[g], prev_d);
        p_s[g] <= prev_s;
      end
    end
  end

  assign out_valid = p_v[NS-1];
  assign out_data  = p_d[NS-1];
  assign out_src   = p_s[NS-1];
endmodule

module rev_cascade_chk #(
  parameter int NW = 4,
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          cfg_reject,
  input logic          in_valid,
  input logic          in_ready,
  input logic          sweep_busy,
  input logic          out_valid,
  input logic [NW-1:0] out_data,
  input logic [NW-1:0] out_src
);
  logic [31:0] since_rst, since_cfg, acc_n, out_n, busy_n;
  logic        prev_ov;
  logic [NW-1:0] prev_d, prev_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= 0; since_cfg <= 0; acc_n <= 0; out_n <= 0; busy_n <= 0;
      prev_ov <= 0; prev_d <= '0; prev_s <= '0;
    end else begin
      if (since_rst < 32'hFFFF) since_rst <= since_rst + 1;
      since_cfg <= cfg_we ? 0 : ((since_cfg < 32'hFFFF) ? since_cfg + 1 : since_cfg);
      acc_n  <= acc_n + 32'(sweep_busy || (in_valid && in_ready));
      out_n  <= out_n + 32'(out_valid);
      busy_n <= sweep_busy ? busy_n + 1 : 0;
      prev_ov <= out_valid; prev_d <= out_data; prev_s <= out_src;
    end
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < NS) |-> !out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_n < acc_n));
  p_reject_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reject |-> $past(cfg_we));
  p_sweep_length_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && busy_n == (32'd1 << NW) - 1) |=> !sweep_busy);
  p_distinct_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_ov && since_cfg > 2*NS && out_src != prev_s) |-> (out_data != prev_d));
  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_busy |-> !in_ready);
endmodule

bind rev_cascade rev_cascade_chk #(.NW(NW), .NS(NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_reject(cfg_reject),
  .in_valid(in_valid), .in_ready(in_ready), .sweep_busy(sweep_busy),
  .out_valid(out_valid), .out_data(out_data), .out_src(out_src));

// File: tb/rev_cascade_test.sv
module rev_cascade_test;
  localparam int NW = 4, NS = 4, IW = 2, SW = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, in_valid = 0, sweep_start = 0;
  logic [SW-1:0] cfg_slot = 0;
  logic [1:0] cfg_kind = 0;
  logic [IW-1:0] cfg_tgt = 0, cfg_aux = 0;
  logic [NW-1:0] cfg_mask = 0, in_data = 0;
  logic cfg_reject, in_ready, sweep_busy, out_valid;
  logic [NW-1:0] out_data, out_src;

  int n_chk = 0, n_fail = 0;
  logic [1:0] mk [NS];
  logic [IW-1:0] mt [NS], ma [NS];
  logic [NW-1:0] mm [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_cascade #(.NW(NW), .NS(NS)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] model(input logic [NW-1:0] v);
    logic [NW-1:0] r, x;
    r = v;
    for (int i = 0; i < NS; i++) begin
      x = r;
      if (mk[i] == 2'b01 && (r & mm[i]) == mm[i]) x[mt[i]] = ~r[mt[i]];
      else if (mk[i] == 2'b10) begin x[mt[i]] = r[ma[i]]; x[ma[i]] = r[mt[i]]; end
      r = x;
    end
    return r;
  endfunction

  task automatic wr(input int s, input logic [1:0] k, input int t, input int a,
                    input logic [NW-1:0] m, input bit rej, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_slot = SW'(s); cfg_kind = k; cfg_tgt = IW'(t); cfg_aux = IW'(a); cfg_mask = m;
    @(negedge clk);
    cfg_we = 0;
    chk(cfg_reject == rej, tag, cfg_reject, rej);
    mk[s] = rej ? 2'b00 : k; mt[s] = IW'(t); ma[s] = IW'(a); mm[s] = m;
  endtask

  task automatic clear_all();
    for (int i = 0; i < NS; i++) wr(i, 2'b00, 0, 0, '0, 0, "R7 legal empty write");
  endtask

  task automatic send(input logic [NW-1:0] v, input string tag);
    logic [NW-1:0] e;
    e = model(v);
    @(negedge clk);
    in_valid = 1; in_data = v;
    @(negedge clk);
    in_valid = 0;
    repeat (NS-2) @(negedge clk);
    chk(!out_valid, "R2 early valid", out_valid, 0);
    @(negedge clk);
    chk(out_valid, "R2 valid at NS", out_valid, 1);
    chk(out_src == v, "R2 src", out_src, v);
    chk(out_data == e, tag, out_data, e);
    @(negedge clk);
    chk(!out_valid, "R2 single cycle", out_valid, 0);
  endtask

  task automatic t_reset();
    chk(!out_valid && !sweep_busy && !cfg_reject, "R1 outputs idle", {out_valid, sweep_busy, cfg_reject}, 0);
    chk(in_ready, "R1 ready", in_ready, 1);
    send(4'hA, "R1 empty identity");
  endtask

  task automatic t_cx();
    clear_all();
    wr(0, 2'b01, 2, 0, 4'b0000, 0, "R3 not write");
    send(4'h0, "R3 not 0"); send(4'h5, "R3 not 5");
    wr(0, 2'b01, 3, 0, 4'b0011, 0, "R3 toffoli write");
    send(4'h3, "R3 toffoli fire"); send(4'h1, "R3 toffoli hold"); send(4'hB, "R3 toffoli back");
    wr(0, 2'b01, 0, 0, 4'b1110, 0, "R3 kcnot write");
    send(4'hE, "R3 kcnot fire"); send(4'h6, "R3 kcnot hold");
  endtask

  task automatic t_swap();
    clear_all();
    wr(1, 2'b10, 0, 3, '0, 0, "R4 swap write");
    send(4'h1, "R4 swap 1"); send(4'h9, "R4 swap 9");
  endtask

  task automatic t_order();
    clear_all();
    wr(0, 2'b01, 1, 0, 4'b0001, 0, "R5 cnot write");
    wr(1, 2'b10, 0, 1, '0, 0, "R5 swap write");
    wr(3, 2'b01, 3, 0, 4'b0000, 0, "R6 not after gap");
    chk(model(4'h1) == 4'hB, "R5 model order", model(4'h1), 4'hB);
    send(4'h1, "R5 order 1"); send(4'h2, "R5 order 2"); send(4'hC, "R6 gap slot");
  endtask

  task automatic t_illegal();
    clear_all();
    wr(0, 2'b01, 2, 0, 4'b0000, 0, "R7 legal not");
    wr(0, 2'b01, 1, 0, 4'b0010, 1, "R7 target in mask");
    send(4'h0, "R7 refused is identity");
    wr(1, 2'b10, 2, 2, '0, 1, "R7 swap same wire");
    wr(2, 2'b11, 0, 0, '0, 1, "R7 reserved kind");
    send(4'h7, "R7 all refused identity");
  endtask

  task automatic t_sweep();
    logic [NW-1:0] seen [1<<NW];
    int got;
    bit ok_src, ok_dat, ok_dst;
    clear_all();
    wr(0, 2'b01, 3, 0, 4'b0011, 0, "R8 cfg a");
    wr(1, 2'b10, 0, 2, '0, 0, "R8 cfg b");
    wr(2, 2'b01, 1, 0, 4'b1000, 0, "R8 cfg c");
    wr(3, 2'b01, 0, 0, 4'b0000, 0, "R8 cfg d");
    @(negedge clk);
    sweep_start = 1;
    @(negedge clk);
    sweep_start = 0;
    chk(sweep_busy && !in_ready, "R10 ready low", in_ready, 0);
    in_valid = 1; in_data = 4'h5;
    got = 0; ok_src = 1; ok_dat = 1;
    for (int c = 0; c < 40; c++) begin
      if (out_valid) begin
        if (got < (1<<NW)) begin
          if (out_src != NW'(got)) ok_src = 0;
          if (out_data != model(NW'(got))) ok_dat = 0;
          seen[got] = out_data;
        end
        got++;
      end
      if (c == 10) in_valid = 0;
      @(negedge clk);
    end
    in_valid = 0;
    chk(got == (1<<NW), "R10 R8 result count", got, 1<<NW);
    chk(ok_src, "R8 src sequence", ok_src, 1);
    chk(ok_dat, "R8 table values", ok_dat, 1);
    ok_dst = 1;
    for (int i = 0; i < (1<<NW); i++)
      for (int j = i+1; j < (1<<NW); j++)
        if (seen[i] == seen[j]) ok_dst = 0;
    chk(ok_dst, "R9 permutation", ok_dst, 1);
    chk(!sweep_busy && in_ready, "R10 ready restored", in_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin mk[i] = 0; mt[i] = 0; ma[i] = 0; mm[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cx();
    t_swap();
    t_order();
    t_illegal();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule